// File: doc/BRIEF.md
# SPI Command Transaction Engine

This block runs one complete SPI transaction that software has composed in advance. A configuration word sets the size of each phase. A command word supplies the opcode and the dummy-phase patterns, an address word supplies the address bytes, and four 32-bit data-out words supply the write payload. When the start pulse arrives, the engine walks through its phases in a fixed order: opcode, address, write data, dummy, read data. Any phase whose size is zero is skipped. Bytes returned during the read phase are stored in four 32-bit data-in words.

The engine does not toggle SPI pins itself. It hands one unit at a time to an external shifter over a request/acknowledge port. Each unit is a byte, or a 1-, 2- or 4-bit chunk during the dummy phase, together with a width code. The received byte comes back with the acknowledge. A ready flag, which software clears, marks completion and can raise an interrupt. The engine drives a chip-select line only when software asks it to.

The configuration, command, address, data-out, software-CS and device-select inputs must stay stable from the start pulse until the ready flag rises.

Top module: `spi_cmd_engine`

## Requirements
- R1: Phases run in the order opcode, address, write, dummy, read, and a zero-sized phase issues no transfer. The sizes are decoded from `cfg_i` as follows: bit 10 is opcode-present, bits 13:11 are the address byte count, bits 20:16 the write byte count, bits 23:21 the dummy unit count, bits 28:24 the read byte count, and bits 7:6 the dummy width code.
- R2: When `cfg_i[10]` is 1, the first transfer carries `cmd_i[7:0]`.
- R3: An address count N from 1 to 4 sends bytes N-1 down to 0 of `addr_i`, most significant first. N of 5 to 7 sends no address byte.
- R4: Write byte i is lane i%4 (bits 8*(i%4)+7 : 8*(i%4)) of data-out word i/4, where word k is `wdata_i[32k+31:32k]`. For i of 16 or more, the lane i%4 of word 3 is used.
- R5: Dummy unit 0 uses `cmd_i[15:8]`, unit 1 uses `cmd_i[23:16]`, and every later unit uses `cmd_i[31:24]`. Each unit is sent as 8>>code chunks of 1<<code bits, lowest chunk first, with code = `cfg_i[7:6]`. Each chunk sits in the low bits of `xfer_tx_o`, its upper bits are zero, and `xfer_wlog_o` equals the code.
- R6: Read byte i is stored into `rdata_o[8i+7:8i]` when i is below 16. Read bytes 16 and above are clocked and discarded, and bytes not read in a transaction keep their earlier value.
- R7: `busy_o` rises on the edge that samples `start_i`. One edge after the last acknowledge, `busy_o` falls and `rdy_o` rises. A transaction with every size zero rises and completes on consecutive edges.
- R8: `rdy_o` clears on an edge where `rdy_clr_i` is 1; if completion falls on the same edge, the set wins. `irq_o` is 1 exactly while both `rdy_o` and `rdy_ie_i` are 1.
- R9: `cs_n_o[dev_sel_i]` is 0 only while `busy_o` and `sw_cs_i` are both 1; every other line stays 1.
- R10: A `start_i` pulse while `busy_o` is 1 has no effect.
- R11: `xfer_req_o` stays 1 with a stable `xfer_tx_o` until `xfer_ack_i` is 1, and each acknowledge consumes one transfer. Opcode, address, write and read transfers use width code 3; read transfers send 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Execute pulse |
| cfg_i | input | 32 | Phase size configuration |
| cmd_i | input | 32 | Opcode and dummy patterns |
| addr_i | input | 32 | Address bytes |
| wdata_i | input | 128 | Four data-out words |
| sw_cs_i | input | 1 | Let the engine drive chip select |
| dev_sel_i | input | 2 | Chip select index |
| rdy_clr_i | input | 1 | Clear the ready flag |
| rdy_ie_i | input | 1 | Ready interrupt enable |
| rdata_o | output | 128 | Four data-in words |
| busy_o | output | 1 | Transaction running (execute flag) |
| rdy_o | output | 1 | Ready status flag |
| irq_o | output | 1 | Interrupt request |
| cs_n_o | output | 4 | Active-low chip selects |
| xfer_req_o | output | 1 | Transfer request to shifter |
| xfer_tx_o | output | 8 | Byte or chunk to send |
| xfer_wlog_o | output | 2 | log2 of bits in the transfer |
| xfer_ack_i | input | 1 | Shifter finished the transfer |
| xfer_rx_i | input | 8 | Byte received with the acknowledge |

## Verification
The request for the first phase is visible one edge after `start_i` is sampled. Each further request follows the edge that consumed the previous acknowledge, and the ready flag appears one edge after the final acknowledge. The bench drives every input on the falling edge and reads the outputs on a later falling edge, so each value is observed half a cycle after the edge that produced it. The shifter model records each request at the falling edge on which it is first seen and answers after a chosen latency. The bench compares the recorded stream with a sequence it builds from the requirements, and it checks the precise one-edge completion timing on an empty transaction.

// File: rtl/spi_txe_pkg.sv
// Shared types and decode helpers for the SPI command transaction engine.
// Assumes the configuration field positions listed in the brief.
package spi_txe_pkg;

    localparam int IDXW = 5;  // wide enough for a 31-byte phase

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_OPC  = 3'd1,
        PH_ADR  = 3'd2,
        PH_WR   = 3'd3,
        PH_DUM  = 3'd4,
        PH_RD   = 3'd5,
        PH_DONE = 3'd6
    } phase_e;

    typedef struct packed {
        logic            op_en;
        logic [2:0]      adr_n;
        logic [IDXW-1:0] wr_n;
        logic [2:0]      dum_n;
        logic [IDXW-1:0] rd_n;
        logic [1:0]      dlog;
    } txcfg_t;

    // Split the configuration word into phase sizes; address counts above 4 send nothing.
    function automatic txcfg_t decode_cfg(input logic [31:0] w);
        txcfg_t c;
        c.op_en = w[10];
        c.adr_n = (w[13:11] > 3'd4) ? 3'd0 : w[13:11];
        c.wr_n  = w[20:16];
        c.dum_n = w[23:21];
        c.rd_n  = w[28:24];
        c.dlog  = w[7:6];
        return c;
    endfunction

    // Number of units (bytes, or dummy units) in a phase.
    function automatic logic [IDXW-1:0] phase_len(input phase_e p, input txcfg_t c);
        case (p)
            PH_OPC:  return {{(IDXW-1){1'b0}}, c.op_en};
            PH_ADR:  return IDXW'(c.adr_n);
            PH_WR:   return c.wr_n;
            PH_DUM:  return IDXW'(c.dum_n);
            PH_RD:   return c.rd_n;
            default: return '0;
        endcase
    endfunction

    // First non-empty phase after p, or PH_DONE when none is left.
    function automatic phase_e next_phase(input phase_e p, input txcfg_t c);
        phase_e n;
        n = PH_DONE;
        for (int k = int'(PH_RD); k > int'(p); k--) begin
            if (phase_len(phase_e'(k), c) != '0) n = phase_e'(k);
        end
        return n;
    endfunction

endpackage

// File: rtl/spi_txe_seq.sv
// Phase sequencer: walks the phases, counts units and dummy chunks, and owns
// the execute (busy) and ready flags. Advances only on a shifter acknowledge.
module spi_txe_seq
    import spi_txe_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  txcfg_t                cfg_i,
    input  logic                  ack_i,
    input  logic                  rdy_clr_i,
    output phase_e                phase_o,
    output logic [IDXW-1:0]       idx_o,
    output logic [2:0]            cnk_o,
    output logic                  busy_o,
    output logic                  rdy_o,
    output logic                  req_o
);

    phase_e          phase_q;
    logic [IDXW-1:0] idx_q;
    logic [2:0]      cnk_q;
    logic            rdy_q;
    logic [IDXW-1:0] len;
    logic [2:0]      cnk_last;

    // Size of the current phase and index of the last chunk of a dummy unit.
    always_comb begin
        len      = phase_len(phase_q, cfg_i);
        cnk_last = 3'd7 >> cfg_i.dlog;
    end

    // Phase, unit and chunk progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            cnk_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (start_i) begin
                    phase_q <= next_phase(PH_IDLE, cfg_i);
                    idx_q   <= '0;
                    cnk_q   <= '0;
                end
                PH_DONE: phase_q <= PH_IDLE;
                default: if (ack_i) begin
                    if (phase_q == PH_DUM && cnk_q != cnk_last) begin
                        cnk_q <= cnk_q + 3'd1;
                    end else begin
                        cnk_q <= '0;
                        if (idx_q == len - 1'b1) begin
                            idx_q   <= '0;
                            phase_q <= next_phase(phase_q, cfg_i);
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // Ready flag: set on completion, cleared by software, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rdy_q <= 1'b0;
        else if (phase_q == PH_DONE) rdy_q <= 1'b1;
        else if (rdy_clr_i)          rdy_q <= 1'b0;
    end

    assign phase_o = phase_q;
    assign idx_o   = idx_q;
    assign cnk_o   = cnk_q;
    assign busy_o  = (phase_q != PH_IDLE);
    assign req_o   = (phase_q != PH_IDLE) && (phase_q != PH_DONE);
    assign rdy_o   = rdy_q;

    // R11: a pending request holds its position until acknowledged.
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> (req_o && $stable(phase_q) && $stable(idx_q) && $stable(cnk_q)));

    // R7: the end of a transaction always leaves the ready flag set.
    p_done_rdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> rdy_o);

    // R10: a start pulse during a running transfer does not move the counters.
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && start_i && !ack_i) |=> ($stable(idx_q) && $stable(cnk_q)));

endmodule

// File: rtl/spi_txe_txmux.sv
// Transmit selector: picks the byte or dummy chunk for the current unit and
// its width code. Purely combinational; assumes its inputs are stable.
module spi_txe_txmux
    import spi_txe_pkg::*;
#(
    parameter int DREGS = 4
) (
    input  phase_e                 phase_i,
    input  logic [IDXW-1:0]        idx_i,
    input  logic [2:0]             cnk_i,
    input  txcfg_t                 cfg_i,
    input  logic [31:0]            cmd_i,
    input  logic [31:0]            addr_i,
    input  logic [DREGS*32-1:0]    wdata_i,
    output logic [7:0]             tx_o,
    output logic [1:0]             wlog_o
);

    localparam int WBYTES = DREGS * 4;

    int          abyte;
    int          wword;
    int          fsel;
    logic [7:0]  dbyte;
    logic [7:0]  dmask;

    // Select the outgoing unit for the active phase.
    always_comb begin
        abyte  = int'(cfg_i.adr_n) - 1 - int'(idx_i);
        wword  = (int'(idx_i) >= WBYTES) ? DREGS - 1 : int'(idx_i) / 4;
        fsel   = (idx_i == '0) ? 1 : ((idx_i == IDXW'(1)) ? 2 : 3);
        dbyte  = cmd_i[fsel*8 +: 8];
        dmask  = 8'hFF >> (4'd8 - (4'd1 << cfg_i.dlog));
        tx_o   = 8'h00;
        wlog_o = 2'd3;
        case (phase_i)
            PH_OPC: tx_o = cmd_i[7:0];
            PH_ADR: tx_o = addr_i[(abyte & 3)*8 +: 8];
            PH_WR:  tx_o = wdata_i[(wword*4 + int'(idx_i[1:0]))*8 +: 8];
            PH_DUM: begin
                tx_o   = (dbyte >> (cnk_i << cfg_i.dlog)) & dmask;
                wlog_o = cfg_i.dlog;
            end
            default: tx_o = 8'h00;
        endcase
    end

endmodule

// File: rtl/spi_txe_rxcap.sv
// Read capture: stores each acknowledged read byte into its data-in lane.
// Indices past the last lane are dropped; other lanes hold their value.
module spi_txe_rxcap
    import spi_txe_pkg::*;
#(
    parameter int DREGS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cap_i,
    input  logic [IDXW-1:0]        idx_i,
    input  logic [7:0]             rx_i,
    output logic [DREGS*32-1:0]    rdata_o
);

    localparam int RBYTES = DREGS * 4;

    for (genvar g = 0; g < RBYTES; g++) begin : g_lane
        // One byte lane, written only when its index is being read.
        always_ff @(posedge clk) begin
            if (!rst_n)                          rdata_o[g*8 +: 8] <= 8'h00;
            else if (cap_i && idx_i == IDXW'(g)) rdata_o[g*8 +: 8] <= rx_i;
        end
    end

endmodule

// File: rtl/spi_cmd_engine.sv
// SPI command transaction engine top: decodes the configuration, sequences
// the phases, drives the shifter port, captures read data and drives the
// chip selects. Configuration inputs must stay stable while busy.
module spi_cmd_engine
    import spi_txe_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int DREGS  = 4,
    localparam int CSW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [31:0]           cfg_i,
    input  logic [31:0]           cmd_i,
    input  logic [31:0]           addr_i,
    input  logic [DREGS*32-1:0]   wdata_i,
    input  logic                  sw_cs_i,
    input  logic [CSW-1:0]        dev_sel_i,
    input  logic                  rdy_clr_i,
    input  logic                  rdy_ie_i,
    output logic [DREGS*32-1:0]   rdata_o,
    output logic                  busy_o,
    output logic                  rdy_o,
    output logic                  irq_o,
    output logic [NUM_CS-1:0]     cs_n_o,
    output logic                  xfer_req_o,
    output logic [7:0]            xfer_tx_o,
    output logic [1:0]            xfer_wlog_o,
    input  logic                  xfer_ack_i,
    input  logic [7:0]            xfer_rx_i
);

    txcfg_t          cfg;
    phase_e          phase;
    logic [IDXW-1:0] idx;
    logic [2:0]      cnk;
    logic            unused_cfg;

    assign cfg        = decode_cfg(cfg_i);
    assign unused_cfg = ^{cfg_i[31:29], cfg_i[15:14], cfg_i[9:8], cfg_i[5:0]};

    spi_txe_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .cfg_i     (cfg),
        .ack_i     (xfer_ack_i),
        .rdy_clr_i (rdy_clr_i),
        .phase_o   (phase),
        .idx_o     (idx),
        .cnk_o     (cnk),
        .busy_o    (busy_o),
        .rdy_o     (rdy_o),
        .req_o     (xfer_req_o)
    );

    spi_txe_txmux #(.DREGS(DREGS)) u_txmux (
        .phase_i (phase),
        .idx_i   (idx),
        .cnk_i   (cnk),
        .cfg_i   (cfg),
        .cmd_i   (cmd_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .tx_o    (xfer_tx_o),
        .wlog_o  (xfer_wlog_o)
    );

    spi_txe_rxcap #(.DREGS(DREGS)) u_rxcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (xfer_ack_i && phase == PH_RD),
        .idx_i   (idx),
        .rx_i    (xfer_rx_i),
        .rdata_o (rdata_o)
    );

    // Chip select lines: only the addressed one, only under software-CS mode.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_n_o[g] = !(busy_o && sw_cs_i && dev_sel_i == CSW'(g));
    end

    assign irq_o = rdy_o && rdy_ie_i;

    // R9: at most one chip select is active at a time.
    p_cs_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));

    // R9: a select is active only during a software-CS transaction.
    p_cs_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_o != {NUM_CS{1'b1}}) |-> (busy_o && sw_cs_i));

    // R11: the shifter is asked for work only while a transaction runs.
    p_req_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |-> busy_o);

    // R8: the interrupt never fires without the ready flag.
    p_irq_rdy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (rdy_o && rdy_ie_i));

endmodule

// File: tb/tb_spi_cmd_engine.sv
// Directed bench for spi_cmd_engine with a latency-programmable shifter model.
module tb_spi_cmd_engine;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [31:0]  cfg_i = '0;
    logic [31:0]  cmd_i = '0;
    logic [31:0]  addr_i = '0;
    logic [127:0] wdata_i = '0;
    logic         sw_cs_i = 1'b0;
    logic [1:0]   dev_sel_i = '0;
    logic         rdy_clr_i = 1'b0;
    logic         rdy_ie_i = 1'b0;
    logic [127:0] rdata_o;
    logic         busy_o, rdy_o, irq_o, xfer_req_o;
    logic [3:0]   cs_n_o;
    logic [7:0]   xfer_tx_o;
    logic [1:0]   xfer_wlog_o;
    logic         xfer_ack_i = 1'b0;
    logic [7:0]   xfer_rx_i = '0;

    always #2.5 clk = ~clk;  // 200 MHz

    spi_cmd_engine dut (.*);

    int n_chk = 0;
    int n_fail = 0;

    // shifter model log
    int         n_log = 0;
    int         lat = 0;
    logic [7:0] seed = 8'h10;
    logic [7:0] lg_tx [256];
    logic [1:0] lg_w  [256];
    logic [7:0] lg_rx [256];
    logic [3:0] lg_cs [256];

    // expected stream
    int         ex_n;
    int         ex_rd;
    logic [7:0] ex_tx [256];
    logic [1:0] ex_w  [256];
    logic [127:0] shadow_rd = '0;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Shifter model: record each request, answer after lat cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (xfer_req_o && !xfer_ack_i) begin
                lg_tx[n_log] = xfer_tx_o;
                lg_w[n_log]  = xfer_wlog_o;
                lg_cs[n_log] = cs_n_o;
                repeat (lat) @(negedge clk);
                xfer_rx_i = seed + 8'(n_log * 7);
                lg_rx[n_log] = xfer_rx_i;
                n_log++;
                xfer_ack_i = 1'b1;
                @(negedge clk);
                xfer_ack_i = 1'b0;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    function automatic logic [31:0] mkcfg(int op, int adr, int wr, int dum, int rd, int dl);
        return (32'(op) << 10) | (32'(adr) << 11) | (32'(wr) << 16) | (32'(dum) << 21)
             | (32'(rd) << 24) | (32'(dl) << 6);
    endfunction

    // Build the expected transfer stream from the requirements.
    task automatic build_exp();
        int adr, w;
        logic [7:0] b;
        ex_n = 0;
        if (cfg_i[10]) begin ex_tx[ex_n] = cmd_i[7:0]; ex_w[ex_n] = 2'd3; ex_n++; end       // R2
        adr = int'(cfg_i[13:11]);
        if (adr <= 4) begin                                                                 // R3
            for (int k = adr - 1; k >= 0; k--) begin
                ex_tx[ex_n] = addr_i[k*8 +: 8]; ex_w[ex_n] = 2'd3; ex_n++;
            end
        end
        for (int i = 0; i < int'(cfg_i[20:16]); i++) begin                                  // R4
            w = (i >= 16) ? 3 : i / 4;
            ex_tx[ex_n] = wdata_i[(w*32) + (i%4)*8 +: 8]; ex_w[ex_n] = 2'd3; ex_n++;
        end
        for (int u = 0; u < int'(cfg_i[23:21]); u++) begin                                  // R5
            b = (u == 0) ? cmd_i[15:8] : (u == 1) ? cmd_i[23:16] : cmd_i[31:24];
            w = 1 << cfg_i[7:6];
            for (int j = 0; j < 8; j += w) begin
                ex_tx[ex_n] = 8'((b >> j) & ((1 << w) - 1)); ex_w[ex_n] = cfg_i[7:6]; ex_n++;
            end
        end
        ex_rd = ex_n;
        for (int i = 0; i < int'(cfg_i[28:24]); i++) begin ex_tx[ex_n] = 8'h00; ex_w[ex_n] = 2'd3; ex_n++; end
    endtask

    // Run one transaction and check stream, read data and chip selects.
    task automatic run_txn(input string name, input logic [31:0] cfg, input logic [31:0] cmd,
                           input logic [31:0] addr, input logic [127:0] wd, input bit swcs,
                           input logic [1:0] dev, input int latency);
        int t;
        int bad;
        logic [3:0] cs_exp;
        @(negedge clk);
        cfg_i = cfg; cmd_i = cmd; addr_i = addr; wdata_i = wd;
        sw_cs_i = swcs; dev_sel_i = dev; lat = latency; seed = seed + 8'h31;
        n_log = 0;
        rdy_clr_i = 1'b1; @(negedge clk); rdy_clr_i = 1'b0;
        build_exp();
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        t = 0;
        while (!rdy_o && t < 5000) begin @(negedge clk); t++; end
        chk(rdy_o && !busy_o, {name, " R7 completion"}, {rdy_o, busy_o}, 2'b10);
        chk(n_log == ex_n, {name, " R1 transfer count"}, n_log, ex_n);
        bad = -1;
        for (int i = 0; i < ex_n && i < n_log; i++)
            if (bad < 0 && (lg_tx[i] !== ex_tx[i] || lg_w[i] !== ex_w[i])) bad = i;
        if (bad >= 0)
            chk(1'b0, {name, " R1 R11 stream"}, {lg_w[bad], lg_tx[bad]}, {ex_w[bad], ex_tx[bad]});
        else
            chk(1'b1, {name, " R1 R11 stream"}, 0, 0);
        for (int i = 0; i < int'(cfg[28:24]) && i < 16; i++)
            shadow_rd[i*8 +: 8] = lg_rx[ex_rd + i];
        chk(rdata_o === shadow_rd, {name, " R6 read data"}, rdata_o, shadow_rd);
        cs_exp = swcs ? ~(4'b1 << dev) : 4'hF;
        bad = -1;
        for (int i = 0; i < n_log; i++) if (bad < 0 && lg_cs[i] !== cs_exp) bad = i;
        chk(bad < 0 && cs_n_o === 4'hF, {name, " R9 chip select"},
            (bad >= 0) ? lg_cs[bad] : cs_n_o, (bad >= 0) ? cs_exp : 4'hF);
    endtask

    task automatic t_reset();
        chk(!busy_o && !rdy_o && !irq_o && !xfer_req_o, "reset R7 flags", {busy_o, rdy_o, irq_o, xfer_req_o}, 0);
        chk(cs_n_o === 4'hF, "reset R9 cs", cs_n_o, 4'hF);
        chk(rdata_o === '0, "reset R6 rdata", rdata_o, 0);
    endtask

    // R7: empty transaction timing, cycle by cycle.
    task automatic t_empty();
        @(negedge clk);
        cfg_i = 32'h0; n_log = 0;
        rdy_clr_i = 1'b1; @(negedge clk); rdy_clr_i = 1'b0;
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        chk(busy_o && !rdy_o, "empty R7 busy edge", {busy_o, rdy_o}, 2'b10);
        @(negedge clk);
        chk(!busy_o && rdy_o && n_log == 0, "empty R7 done edge", {busy_o, rdy_o, 8'(n_log)}, 10'b0100000000);
    endtask

    // R8: ready clear, set-wins, and interrupt gating.
    task automatic t_irq();
        rdy_ie_i = 1'b0; @(negedge clk);
        chk(rdy_o && !irq_o, "R8 irq masked", {rdy_o, irq_o}, 2'b10);
        rdy_ie_i = 1'b1; @(negedge clk);
        chk(irq_o, "R8 irq enabled", irq_o, 1);
        rdy_clr_i = 1'b1; @(negedge clk); rdy_clr_i = 1'b0;
        chk(!rdy_o && !irq_o, "R8 clear", {rdy_o, irq_o}, 0);
        cfg_i = 32'h0;
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        rdy_clr_i = 1'b1; @(negedge clk); rdy_clr_i = 1'b0;
        chk(rdy_o && irq_o, "R8 set wins over clear", {rdy_o, irq_o}, 2'b11);
        rdy_ie_i = 1'b0;
    endtask

    // R10: a second start while busy changes nothing.
    task automatic t_restart();
        int t;
        @(negedge clk);
        cfg_i = mkcfg(1, 1, 0, 0, 3, 0); cmd_i = 32'h0000_009F; addr_i = 32'h77;
        sw_cs_i = 1'b0; lat = 2; n_log = 0;
        rdy_clr_i = 1'b1; @(negedge clk); rdy_clr_i = 1'b0;
        build_exp();
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        repeat (4) @(negedge clk);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        t = 0;
        while (!rdy_o && t < 5000) begin @(negedge clk); t++; end
        repeat (20) @(negedge clk);
        chk(n_log == ex_n && !busy_o, "R10 restart ignored", {busy_o, 8'(n_log)}, 8'(ex_n));
        for (int i = 0; i < 3; i++) shadow_rd[i*8 +: 8] = lg_rx[ex_rd + i];
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        run_txn("full", mkcfg(1, 3, 2, 1, 4, 3), 32'hC3B2_A10B, 32'h0012_3456,
                128'h0f0e0d0c_0b0a0908_07060504_03020100, 1'b0, 2'd0, 0);
        run_txn("addr2", mkcfg(1, 2, 0, 0, 0, 0), 32'h0000_0003, 32'hDEAD_BEEF, '0, 1'b1, 2'd2, 1);
        run_txn("addr4", mkcfg(0, 4, 0, 0, 1, 0), 32'h0, 32'h89AB_CDEF, '0, 1'b1, 2'd1, 0);
        run_txn("addr7", mkcfg(1, 7, 1, 0, 0, 0), 32'h0000_0055, 32'h1122_3344, 128'hAA, 1'b0, 2'd0, 0);
        run_txn("wr18", mkcfg(0, 0, 18, 0, 0, 0), 32'h0, 32'h0,
                128'hF3F2F1F0_E3E2E1E0_D3D2D1D0_C3C2C1C0, 1'b1, 2'd3, 1);
        run_txn("dum1b", mkcfg(0, 0, 0, 3, 0, 0), 32'h5AC3_3C00, 32'h0, '0, 1'b0, 2'd0, 0);
        run_txn("dum2b", mkcfg(0, 0, 0, 4, 0, 1), 32'h9E6B_A700, 32'h0, '0, 1'b0, 2'd0, 2);
        run_txn("dum4b", mkcfg(1, 0, 0, 2, 1, 2), 32'h0000_E7EB, 32'h0, '0, 1'b0, 2'd0, 0);
        run_txn("rd18", mkcfg(1, 0, 0, 0, 18, 0), 32'h0000_0066, 32'h0, '0, 1'b1, 2'd0, 0);
        run_txn("rd2", mkcfg(0, 0, 0, 0, 2, 0), 32'h0, 32'h0, '0, 1'b0, 2'd0, 3);
        t_empty();
        t_irq();
        t_restart();
        chk(rdata_o === shadow_rd, "R6 after restart test", rdata_o, shadow_rd);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule